// File: doc/BRIEF.md
# Comparator Output Filter and Status

This block is the digital back end of an analog comparator. The raw comparator decision arrives as a single bit. The block passes it through a two-flop synchronizer and samples it, either every N bus clocks or on each cycle that an external sample strobe is high. A new filtered level is accepted only after four consecutive samples agree on it. When the programmed interval is zero and the strobe source is not selected, the filter is bypassed and the output follows the synchronized input.

Edges of the filtered level set sticky rise and fall flags, which software clears by writing one. The flags, masked by their enables, raise either an interrupt request or a DMA request, depending on a routing bit. A byte-wide register port holds four registers: control, input select, interval and status. The block switches itself off when the enable bit is clear or when both input select fields hold the same code.

Top module: `cmp_filter_status`

## Requirements
- R1: After reset every register reads 0x00, and `filt_out`, `pin_out`, `pin_oe`, `irq` and `dma_req` are 0.
- R2: With a nonzero interval P (address 2) and the strobe source off, one sample is taken every P clocks. `filt_out` changes only on the fourth consecutive sample that differs from it, and a run shorter than that leaves it unchanged.
- R3: With interval 0 and the strobe source off, `filt_out` takes the synchronized input value one clock later.
- R4: With the strobe source selected (control bit 2), each clock on which `sample_in` is high takes one sample and the interval register has no effect.
- R5: With the enable (control bit 0) clear, `filt_out` is held at 0 and no flag is set.
- R6: When the positive select (address 1 bits 2:0) equals the negative select (bits 5:3), the block behaves as disabled regardless of the enable bit.
- R7: `pin_oe` equals the pin enable (control bit 1), and `pin_out` is `filt_out` AND that bit.
- R8: Status bit 1 (rise) is set on a 0-to-1 change of `filt_out` and status bit 2 (fall) on a 1-to-0 change, in the same clock as the change. Writing 1 to either bit clears it, and a set in the same clock as a clear wins.
- R9: Let request = (rise AND bit 3) OR (fall AND bit 4) of status. When status bit 5 is 0, `irq` equals the request and `dma_req` is 0. When bit 5 is 1, `dma_req` equals the request and `irq` is 0.
- R10: Status bit 0 reads `filt_out`, and writes to that bit have no effect.
- R11: A change on `raw_in` reaches `filt_out` in bypass mode three clocks later, through the two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Raw comparator decision, asynchronous |
| sample_in | input | 1 | External sample strobe, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data, combinational from `addr` |
| filt_out | output | 1 | Filtered comparator level |
| pin_out | output | 1 | Gated value for the output pin |
| pin_oe | output | 1 | Output pin drive enable |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions assume that `sample_in` and the register writes are synchronous to `clk`. Only `raw_in` may change at any time, and it is first observed through the synchronizer. The bench drives every input on the falling edge, so each rising edge sees stable values. Strobes are single-cycle pulses, and status writes always carry the intended enable bits along with the clear bits. This keeps the flag and request properties tied to real edges of the filtered level and not to arbitrary writes.

// File: rtl/cmp_filter_status.sv
module cmp_filter_status #(
  parameter int PER_W = 8,
  parameter int SEL_W = 3,
  parameter int AGREE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic       sample_in,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       filt_out,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       irq,
  output logic       dma_req
);
  localparam int SW = (AGREE > 2) ? $clog2(AGREE) : 1;
  localparam logic [SW-1:0] LAST = SW'(AGREE - 1);

  logic             en_q, pin_en_q, ext_q;
  logic [SEL_W-1:0] pos_q, neg_q;
  logic [PER_W-1:0] per_q, cnt_q;
  logic             ie_r_q, ie_f_q, dma_en_q, fl_r_q, fl_f_q;
  logic             s1_q, s2_q, filt_q, filt_d;
  logic [SW-1:0]    streak_q, streak_d;
  logic             active, bypass, per_hit, tick, rise_ev, fall_ev, req;
  logic             wr_ctl, wr_mux, wr_per, wr_st;

  assign active  = en_q && (pos_q != neg_q);
  assign bypass  = !ext_q && (per_q == '0);
  assign per_hit = (per_q != '0) && (cnt_q >= per_q - 1'b1);
  assign tick    = active && (ext_q ? sample_in : per_hit);

  assign wr_ctl = wr_en && (addr == 2'd0);
  assign wr_mux = wr_en && (addr == 2'd1);
  assign wr_per = wr_en && (addr == 2'd2);
  assign wr_st  = wr_en && (addr == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!active || ext_q || per_q == '0 || per_hit)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    filt_d   = filt_q;
    streak_d = streak_q;
    if (!active) begin
      filt_d   = 1'b0;
      streak_d = '0;
    end else if (bypass) begin
      filt_d   = s2_q;
      streak_d = '0;
    end else if (tick) begin
      if (s2_q == filt_q)
        streak_d = '0;
      else if (streak_q == LAST) begin
        filt_d   = s2_q;
        streak_d = '0;
      end else
        streak_d = streak_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q   <= 1'b0;
      streak_q <= '0;
    end else begin
      filt_q   <= filt_d;
      streak_q <= streak_d;
    end
  end

  assign rise_ev = active && filt_d && !filt_q;
  assign fall_ev = active && !filt_d && filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_r_q <= 1'b0;
      fl_f_q <= 1'b0;
    end else begin
      fl_r_q <= rise_ev || (fl_r_q && !(wr_st && wr_data[1]));
      fl_f_q <= fall_ev || (fl_f_q && !(wr_st && wr_data[2]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pin_en_q <= 1'b0;
      ext_q    <= 1'b0;
      pos_q    <= '0;
      neg_q    <= '0;
      per_q    <= '0;
      ie_r_q   <= 1'b0;
      ie_f_q   <= 1'b0;
      dma_en_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        en_q     <= wr_data[0];
        pin_en_q <= wr_data[1];
        ext_q    <= wr_data[2];
      end
      if (wr_mux) begin
        pos_q <= wr_data[SEL_W-1:0];
        neg_q <= wr_data[2*SEL_W-1:SEL_W];
      end
      if (wr_per)
        per_q <= wr_data[PER_W-1:0];
      if (wr_st) begin
        ie_r_q   <= wr_data[3];
        ie_f_q   <= wr_data[4];
        dma_en_q <= wr_data[5];
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rd_data = {5'b0, ext_q, pin_en_q, en_q};
      2'd1:    rd_data = 8'({neg_q, pos_q});
      2'd2:    rd_data = 8'(per_q);
      default: rd_data = {2'b0, dma_en_q, ie_f_q, ie_r_q, fl_f_q, fl_r_q, filt_q};
    endcase
  end

  assign req      = (fl_r_q && ie_r_q) || (fl_f_q && ie_f_q);
  assign irq      = req && !dma_en_q;
  assign dma_req  = req && dma_en_q;
  assign filt_out = filt_q;
  assign pin_out  = filt_q && pin_en_q;
  assign pin_oe   = pin_en_q;

  // R5
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !filt_out);

  // R8
  rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_out) |-> fl_r_q);

  // R8
  fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_out) && $past(active) |-> fl_f_q);

  // R9
  req_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));

  // R7
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) && !$past(bypass) && !$past(tick) |-> $stable(filt_out));
endmodule

// File: tb/sim_cmp_filter_status.sv
module sim_cmp_filter_status;
  localparam int CLK_PER = 10;

  logic clk = 0, rst_n = 0, raw_in = 0, sample_in = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic filt_out, pin_out, pin_oe, irq, dma_req;
  int checks = 0, errors = 0;
  bit done = 0;

  cmp_filter_status u0 (.clk, .rst_n, .raw_in, .sample_in, .wr_en, .addr,
    .wr_data, .rd_data, .filt_out, .pin_out, .pin_oe, .irq, .dma_req);

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference state
  bit m_en, m_pin, m_ext, m_ier, m_ief, m_dma, m_fr, m_ff, m_filt, m_s1, m_s2;
  int m_pos, m_neg, m_per, m_pc, m_str;

  function automatic logic [7:0] mread(input int a);
    case (a)
      0: return {5'b0, m_ext, m_pin, m_en};
      1: return 8'((m_neg << 3) | m_pos);
      2: return 8'(m_per);
      default: return {2'b0, m_dma, m_ief, m_ier, m_ff, m_fr, m_filt};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_en, m_pin, m_ext, m_ier, m_ief, m_dma, m_fr, m_ff, m_filt, m_s1, m_s2} = '0;
      m_pos = 0; m_neg = 0; m_per = 0; m_pc = 0; m_str = 0;
    end else begin
      bit on, tk, nf, up, dn;
      int ns, np;
      on = m_en && (m_pos != m_neg);
      nf = m_filt; ns = m_str; np = m_pc; tk = 0;
      if (!on) begin nf = 0; ns = 0; np = 0; end
      else if (m_ext) begin tk = sample_in; np = 0; end
      else if (m_per == 0) begin nf = m_s2; ns = 0; np = 0; end
      else if (m_pc >= m_per - 1) begin tk = 1; np = 0; end
      else np = m_pc + 1;
      if (on && tk) begin
        if (m_s2 == m_filt) ns = 0;
        else if (m_str == 3) begin nf = m_s2; ns = 0; end
        else ns = m_str + 1;
      end
      up = on && nf && !m_filt;
      dn = on && !nf && m_filt;
      m_fr = up || (m_fr && !(wr_en && addr == 3 && wr_data[1]));
      m_ff = dn || (m_ff && !(wr_en && addr == 3 && wr_data[2]));
      if (wr_en) begin
        case (addr)
          0: begin m_en = wr_data[0]; m_pin = wr_data[1]; m_ext = wr_data[2]; end
          1: begin m_pos = int'(wr_data[2:0]); m_neg = int'(wr_data[5:3]); end
          2: m_per = int'(wr_data);
          default: begin m_ier = wr_data[3]; m_ief = wr_data[4]; m_dma = wr_data[5]; end
        endcase
      end
      m_s2 = m_s1; m_s1 = raw_in;
      m_filt = nf; m_str = ns; m_pc = np;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit rq;
    rq = (m_fr && m_ier) || (m_ff && m_ief);
    chk(filt_out == m_filt, "R2 filt_out vs model", filt_out, m_filt);
    chk(pin_out == (m_filt && m_pin) && pin_oe == m_pin, "R7 pin", {pin_oe, pin_out}, {m_pin, m_filt && m_pin});
    chk(irq == (rq && !m_dma) && dma_req == (rq && m_dma), "R9 requests", {irq, dma_req}, {rq && !m_dma, rq && m_dma});
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 2'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, input string tag);
    addr = 2'(a); #1;
    chk(rd_data == mread(a), tag, rd_data, mread(a));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset values
    for (int a = 0; a < 4; a++) begin addr = 2'(a); #1; chk(rd_data == 8'h00, "R1 reset reg", rd_data, 0); end
    chk({filt_out, pin_out, pin_oe, irq, dma_req} == 5'b0, "R1 reset outputs", {filt_out, pin_out, pin_oe, irq, dma_req}, 0);

    wr(1, 8'h11); wr(0, 8'h03);
    // R11 / R3 latency in bypass
    raw_in = 1;
    cyc(2); chk(filt_out == 0, "R11 not yet through sync", filt_out, 0);
    cyc(1); chk(filt_out == 1, "R3 bypass follows input", filt_out, 1);
    rd(3, "R8 rise flag and R10 cout");
    chk(rd_data[1] == 1, "R8 rise flag set", rd_data[1], 1);
    wr(3, 8'h02); rd(3, "R8 w1c rise");
    chk(rd_data[1] == 0, "R8 rise cleared", rd_data[1], 0);

    // R8 set wins over clear
    raw_in = 0; cyc(2);
    wr_en = 1; addr = 3; wr_data = 8'h04;
    cyc(1); wr_en = 0;
    rd(3, "R8 set wins");
    chk(rd_data[2] == 1, "R8 fall flag survives clear", rd_data[2], 1);
    wr(3, 8'h06);

    // R2 interval filter
    wr(2, 3); cyc(10);
    raw_in = 1; cyc(5); raw_in = 0; cyc(20);
    chk(filt_out == 0, "R2 short run rejected", filt_out, 0);
    raw_in = 1; cyc(30);
    chk(filt_out == 1, "R2 long run accepted", filt_out, 1);
    rd(2, "R2 interval readback");

    // R4 strobe source, interval ignored
    wr(0, 8'h07); raw_in = 0; cyc(40);
    chk(filt_out == 1, "R4 no strobe no change", filt_out, 1);
    for (int i = 0; i < 3; i++) begin sample_in = 1; cyc(1); sample_in = 0; cyc(2); end
    chk(filt_out == 1, "R4 three strobes not enough", filt_out, 1);
    sample_in = 1; cyc(1); sample_in = 0; cyc(1);
    chk(filt_out == 0, "R4 fourth strobe accepts", filt_out, 0);

    // R6 equal selects disable
    wr(0, 8'h03); wr(2, 0); raw_in = 1; cyc(5); wr(3, 8'h06);
    wr(1, 8'h12); cyc(3);
    chk(filt_out == 0, "R6 equal selects force off", filt_out, 0);
    rd(3, "R6 status");
    chk(rd_data[2:1] == 2'b00, "R6 no flags while off", rd_data[2:1], 0);

    // R5 enable clear
    wr(1, 8'h11); cyc(3); wr(3, 8'h06);
    wr(0, 8'h02); cyc(3);
    chk(filt_out == 0 && pin_out == 0, "R5 disabled holds zero", filt_out, 0);
    rd(3, "R5 status");
    chk(rd_data[2:1] == 2'b00, "R5 no flags while off", rd_data[2:1], 0);

    // R9 interrupt then DMA routing
    wr(3, 8'h08); wr(0, 8'h03); cyc(3);
    chk(irq == 1 && dma_req == 0, "R9 irq path", {irq, dma_req}, 2'b10);
    wr(3, 8'h28); cyc(1);
    chk(irq == 0 && dma_req == 1, "R9 dma path", {irq, dma_req}, 2'b01);
    wr(3, 8'h22); cyc(1);
    chk(dma_req == 0, "R9 request drops on clear", dma_req, 0);

    // R7 pin gating
    wr(0, 8'h01); cyc(1);
    chk(pin_out == 0 && pin_oe == 0 && filt_out == 1, "R7 pin off", {pin_oe, pin_out}, 0);

    // R10 cout read-only
    raw_in = 0; cyc(5); wr(3, 8'h01); rd(3, "R10 cout write ignored");
    chk(rd_data[0] == 0, "R10 cout follows filt", rd_data[0], 0);
    rd(0, "R1 control readback"); rd(1, "R6 select readback");

    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule